// File: doc/BRIEF.md
# Four-Bit Character LCD Write Controller

This block writes to a 16-column, 2-line character display over a four-bit data bus. Once reset is released it wakes the display on its own and sets it up. It first waits out the power-up period. It then sends a short run of lone nibbles that force the display into four-bit mode, followed by four configuration instructions. From then on it takes one command at a time. A command is a data byte, an instruction byte, or a cursor code that the block turns into a display-memory address.

Every byte goes out as two nibbles, high half first. Each nibble gets a set-up interval and a strobe pulse. The block then waits a fixed time so that the display can finish its work. It never reads the display's busy flag: all intervals are counted in clock cycles and scale with the `CLK_MHZ` parameter.

A drive-enable output is high while the block owns the shared data lines and drops as soon as the last nibble of a byte is out. Another agent can then use those lines during the settling wait. A request is taken only in a cycle where `ready` is high.

Top module: `lcd_nibble_writer`

## Requirements
- R1: In reset, and in the cycles right after it, `ready`, `lcd_e`, `lcd_drive` and `lcd_rw` are 0. `ready` stays 0 until the whole start-up sequence has been sent.
- R2: The first strobe comes at least 15 ms after reset is released. It and the next three strobes carry the nibbles 3, 3, 3, 2 with `lcd_rs` = 0. The gaps from each strobe's falling edge to the next rising edge are at least 4.1 ms, 100 us, 40 us and 40 us.
- R3: After the wake-up nibbles, the instructions 0x28, 0x06, 0x0C and 0x01 are written in that order. `ready` then rises.
- R4: Every byte is sent as its bits 7:4 and then its bits 3:0. There is at least 1 us from the first strobe's fall to the second strobe's rise. At least 40 us pass after the second strobe before the next strobe or before `ready` rises.
- R5: An instruction byte of 0x01, 0x02 or 0x03 (clear or home) is followed by at least 1.64 ms of quiet before the next strobe or `ready`.
- R6: `lcd_e` stays high for at least 1 us. `lcd_rs` and `lcd_db` hold their values for at least one cycle (at least 40 ns) before `lcd_e` rises, and they do not change while it is high.
- R7: `cmd_kind` = 2'b00 writes `cmd_byte` as data with `lcd_rs` = 1. `cmd_kind` = 2'b01 writes it as an instruction with `lcd_rs` = 0. `lcd_rw` is always 0.
- R8: When bit 1 of `cmd_kind` is set, bit 0 of `cmd_kind` is not used and a cursor instruction (`lcd_rs` = 0) is written. If `cmd_byte` bit 4 is 1, the address is 0x80 plus `cmd_byte[3:0]`; otherwise it is 0xC0 plus `cmd_byte[3:0]`. `cmd_byte[7:5]` are ignored.
- R9: `lcd_drive` is high whenever `lcd_e` is high. It falls after the last strobe of each byte or lone nibble, and it is 0 whenever `ready` is 1.
- R10: `ready` is 0 from the cycle after a request is accepted until the byte and its settling wait are complete. A request made while `ready` is 0 is ignored and sends no nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Command request, taken when `ready` is high |
| cmd_kind | input | 2 | 00 data, 01 instruction, 1x cursor code |
| cmd_byte | input | 8 | Byte to send, or the cursor code |
| ready | output | 1 | High when a new command can be accepted |
| lcd_e | output | 1 | Display strobe |
| lcd_rs | output | 1 | Register select: 0 instruction, 1 data |
| lcd_rw | output | 1 | Read/write select, held at 0 (write) |
| lcd_db | output | 4 | Data nibble, display bits 7:4 |
| lcd_drive | output | 1 | High while the block owns the data lines |

## Verification
The cases that are hardest to reach from the ports are a request made while a byte is in flight, and the long quiet time after a clear instruction. Both lie behind more than 20 ms of start-up sequence. The bench therefore builds the block with a small `CLK_MHZ`, so that every millisecond costs only a few thousand cycles. It pulses `req` with a distinctive byte right after an accepted command, while `ready` is low. Any extra strobe would then show up as an unexpected nibble in the reference queue. It also issues clear and home instructions and measures the distance to the next strobe in cycles.

// File: rtl/lcd_wr_pkg.sv
// Shared types and timing constants for the four-bit LCD write controller.
// Assumes: all times are whole microseconds; cycle counts are formed in the
// modules from the CLK_MHZ parameter.
package lcd_wr_pkg;

    localparam int STEP_W    = 4;
    localparam int WAIT_W    = 14;
    localparam int PWR_US    = 15100;  // power-up wait, above 15 ms
    localparam int GAP_US    = 1;      // between the two nibbles of a byte
    localparam int BYTE_US   = 40;     // settling after an ordinary byte
    localparam int SLOW_US   = 2000;   // settling after clear or home
    localparam logic [STEP_W-1:0] INIT_LAST = 4'd8;

    typedef enum logic [2:0] {
        SQ_BOOT, SQ_POST, SQ_HI, SQ_GAP, SQ_LO, SQ_IDLE
    } sq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_HIGH
    } strobe_phase_t;

    typedef struct packed {
        logic              is_byte;
        logic [7:0]        value;
        logic [WAIT_W-1:0] wait_us;
    } init_step_t;

    // Maps {line select, column} to a display-memory address instruction.
    function automatic logic [7:0] cursor_addr(input logic [4:0] code);
        return {1'b1, ~code[4], 2'b00, code[3:0]};
    endfunction

endpackage

// File: rtl/lcd_init_table.sv
// Start-up step table: lone wake-up nibbles, then the configuration bytes,
// each with the wait that follows it.
// Assumes: step 0 is the power-up wait and is never looked up here.
module lcd_init_table
    import lcd_wr_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output init_step_t        step
);

    // Purpose: return the nibble or byte and its settling time for one step.
    always_comb begin
        case (idx)
            4'd1:    step = '{1'b0, 8'h03, 14'd4200};
            4'd2:    step = '{1'b0, 8'h03, 14'd110};
            4'd3:    step = '{1'b0, 8'h03, 14'd40};
            4'd4:    step = '{1'b0, 8'h02, 14'd40};
            4'd5:    step = '{1'b1, 8'h28, 14'd40};
            4'd6:    step = '{1'b1, 8'h06, 14'd40};
            4'd7:    step = '{1'b1, 8'h0C, 14'd40};
            4'd8:    step = '{1'b1, 8'h01, 14'(SLOW_US)};
            default: step = '{1'b0, 8'h00, 14'd0};
        endcase
    end

endmodule

// File: rtl/lcd_wr_timer.sv
// Loadable down-counter. A load of N makes expire true in the Nth cycle
// after the loading edge.
// Assumes: count is at least 1 when load is high.
module lcd_wr_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] count,
    output logic         expire
);

    logic [W-1:0] cnt;
    logic         run;

    // Purpose: count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= count - 1'b1;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expire = run && (cnt == '0);

endmodule

// File: rtl/lcd_nibble_strobe.sv
// Sends one nibble: latches nibble and register select, holds the strobe low
// for SU_CYC cycles, high for EH_CYC cycles, then pulses done once.
// Assumes: start is only raised while the previous nibble has finished.
module lcd_nibble_strobe
    import lcd_wr_pkg::*;
#(
    parameter int SU_CYC = 2,
    parameter int EH_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] nib_in,
    input  logic       rs_in,
    output logic       e,
    output logic       rs,
    output logic [3:0] db,
    output logic       done
);

    localparam int MAXC = (SU_CYC > EH_CYC) ? SU_CYC : EH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    strobe_phase_t phase;
    logic [CW-1:0] cnt;

    // Purpose: step through set-up and strobe-high intervals for one nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            e     <= 1'b0;
            rs    <= 1'b0;
            db    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    db    <= nib_in;
                    rs    <= rs_in;
                    cnt   <= CW'(SU_CYC - 1);
                    phase <= PH_SETUP;
                end
                PH_SETUP: if (cnt == '0) begin
                    e     <= 1'b1;
                    cnt   <= CW'(EH_CYC - 1);
                    phase <= PH_HIGH;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_HIGH: if (cnt == '0) begin
                    e     <= 1'b0;
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_nibble_writer.sv
// Top level: power-up and configuration sequencer plus command path for a
// four-bit character display. Fixed delays replace busy-flag polling.
// Assumes: CLK_MHZ is the clock rate in whole MHz; the display is only written.
module lcd_nibble_writer
    import lcd_wr_pkg::*;
#(
    parameter int CLK_MHZ = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] cmd_kind,
    input  logic [7:0] cmd_byte,
    output logic       ready,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic [3:0] lcd_db,
    output logic       lcd_drive
);

    localparam int SU_CYC   = (CLK_MHZ * 40 + 999) / 1000;
    localparam int EH_CYC   = CLK_MHZ;
    localparam int PWR_CYC  = PWR_US * CLK_MHZ;
    localparam int TW       = $clog2(PWR_CYC + 1);
    localparam logic [TW-1:0] GAP_CYC  = TW'(GAP_US * CLK_MHZ);
    localparam logic [TW-1:0] BYTE_CYC = TW'(BYTE_US * CLK_MHZ);
    localparam logic [TW-1:0] SLOW_CYC = TW'(SLOW_US * CLK_MHZ);

    sq_state_t         state;
    logic [STEP_W-1:0] step;
    logic [7:0]        byte_q;
    logic              rs_q;
    logic [TW-1:0]     post_cyc;
    logic              drive_q;

    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_count;
    logic              stb_start, stb_done, stb_rs;
    logic [3:0]        stb_nib;
    init_step_t        nxt;
    logic [TW-1:0]     nxt_wait;
    logic [7:0]        req_byte;
    logic              req_rs, req_slow;

    lcd_init_table u_table (.idx(step + 1'b1), .step(nxt));

    lcd_wr_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .count(tmr_count), .expire(tmr_exp)
    );

    lcd_nibble_strobe #(.SU_CYC(SU_CYC), .EH_CYC(EH_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n), .start(stb_start), .nib_in(stb_nib),
        .rs_in(stb_rs), .e(lcd_e), .rs(lcd_rs), .db(lcd_db), .done(stb_done)
    );

    assign nxt_wait = TW'(CLK_MHZ * int'(nxt.wait_us));
    assign req_byte = cmd_kind[1] ? cursor_addr(cmd_byte[4:0]) : cmd_byte;
    assign req_rs   = (cmd_kind == 2'b00);
    assign req_slow = (cmd_kind == 2'b01) && (cmd_byte[7:2] == 6'd0)
                      && (cmd_byte[1:0] != 2'd0);

    // Purpose: decide timer loads and nibble launches for the current state.
    always_comb begin
        tmr_load  = 1'b0;
        tmr_count = '0;
        stb_start = 1'b0;
        stb_nib   = byte_q[3:0];
        stb_rs    = rs_q;
        case (state)
            SQ_BOOT: begin
                tmr_load  = 1'b1;
                tmr_count = TW'(PWR_CYC);
            end
            SQ_POST: if (tmr_exp && step != INIT_LAST) begin
                stb_start = 1'b1;
                stb_nib   = nxt.is_byte ? nxt.value[7:4] : nxt.value[3:0];
                stb_rs    = 1'b0;
            end
            SQ_HI: if (stb_done) begin
                tmr_load  = 1'b1;
                tmr_count = GAP_CYC;
            end
            SQ_GAP: stb_start = tmr_exp;
            SQ_LO: if (stb_done) begin
                tmr_load  = 1'b1;
                tmr_count = post_cyc;
            end
            SQ_IDLE: if (req) begin
                stb_start = 1'b1;
                stb_nib   = req_byte[7:4];
                stb_rs    = req_rs;
            end
            default: ;
        endcase
    end

    // Purpose: advance the start-up steps and the per-byte nibble sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_BOOT;
            step     <= '0;
            byte_q   <= '0;
            rs_q     <= 1'b0;
            post_cyc <= '0;
            drive_q  <= 1'b0;
        end else begin
            case (state)
                SQ_BOOT: state <= SQ_POST;
                SQ_POST: if (tmr_exp) begin
                    if (step != INIT_LAST) begin
                        step     <= step + 1'b1;
                        drive_q  <= 1'b1;
                        byte_q   <= nxt.value;
                        rs_q     <= 1'b0;
                        post_cyc <= nxt_wait;
                        state    <= nxt.is_byte ? SQ_HI : SQ_LO;
                    end else begin
                        state <= SQ_IDLE;
                    end
                end
                SQ_HI:  if (stb_done) state <= SQ_GAP;
                SQ_GAP: if (tmr_exp)  state <= SQ_LO;
                SQ_LO: if (stb_done) begin
                    drive_q <= 1'b0;
                    state   <= SQ_POST;
                end
                SQ_IDLE: if (req) begin
                    byte_q   <= req_byte;
                    rs_q     <= req_rs;
                    post_cyc <= req_slow ? SLOW_CYC : BYTE_CYC;
                    drive_q  <= 1'b1;
                    state    <= SQ_HI;
                end
                default: state <= SQ_BOOT;
            endcase
        end
    end

    assign ready     = (state == SQ_IDLE);
    assign lcd_drive = drive_q;
    assign lcd_rw    = 1'b0;

endmodule

// File: rtl/lcd_nibble_writer_chk.sv
// Port-level checker for the four-bit LCD write controller, bound to the top.
// Assumes: the same CLK_MHZ as the bound instance.
module lcd_nibble_writer_chk #(
    parameter int CLK_MHZ = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       ready,
    input logic       lcd_e,
    input logic       lcd_rs,
    input logic [3:0] lcd_db,
    input logic       lcd_drive
);

    logic [15:0] hi_cnt;

    // Purpose: measure how many cycles the strobe has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_cnt <= '0;
        else if (lcd_e) hi_cnt <= hi_cnt + 1'b1;
        else            hi_cnt <= '0;
    end

    p_drive_covers_e_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> lcd_drive);

    p_ready_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!lcd_drive && !lcd_e));

    p_hold_while_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    p_setup_before_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    p_e_min_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (hi_cnt >= 16'(CLK_MHZ)));

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

endmodule

bind lcd_nibble_writer lcd_nibble_writer_chk #(.CLK_MHZ(CLK_MHZ)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .lcd_e(lcd_e),
    .lcd_rs(lcd_rs), .lcd_db(lcd_db), .lcd_drive(lcd_drive)
);

// File: tb/lcd_nibble_writer_bench.sv
`timescale 1ns/1ps
// Bench: a queue of expected nibbles with minimum gaps, checked at every
// clock against the strobe, select, drive and ready pins.
module lcd_nibble_writer_bench;

    localparam int C = 2;  // cycles per microsecond seen by the design

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic [7:0] cmd_byte = 8'h00;
    logic       ready, lcd_e, lcd_rs, lcd_rw, lcd_drive;
    logic [3:0] lcd_db;

    lcd_nibble_writer #(.CLK_MHZ(C)) u_lcd_nibble_writer (
        .clk(clk), .rst_n(rst_n), .req(req), .cmd_kind(cmd_kind),
        .cmd_byte(cmd_byte), .ready(ready), .lcd_e(lcd_e), .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw), .lcd_db(lcd_db), .lcd_drive(lcd_drive)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    bit finished = 0, started = 0;

    bit       q_rs[$];
    bit [3:0] q_nib[$];
    int       q_gap[$];
    int       q_tag[$];
    int       post_need = 0;
    int       last_fall = 0;
    int       hi = 0;
    bit       p_e = 0, p_rs = 0, p_ready = 0;
    bit [3:0] p_db = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input int rq, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic push(input bit rs, input bit [3:0] nib, input int gap_us,
                        input int tag);
        q_rs.push_back(rs); q_nib.push_back(nib);
        q_gap.push_back(gap_us * C); q_tag.push_back(tag);
    endtask

    // Model of one byte: high nibble after the previous settling time, low
    // nibble at least 1 us later (R4); clear/home demands 1.64 ms (R5).
    task automatic push_byte(input bit rs, input bit [7:0] b, input bit slow,
                             input int tag);
        push(rs, b[7:4], post_need, tag);
        push(rs, b[3:0], 1, 4);
        post_need = slow ? 1640 : 40;
    endtask

    task automatic send(input bit [1:0] kind, input bit [7:0] din, input int tag);
        bit [7:0] b;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; cmd_kind = kind; cmd_byte = din;
        @(posedge clk);
        // R8: cursor code bit 4 picks 0x80 or 0xC0, low nibble is the column
        b = kind[1] ? ((din[4] ? 8'h80 : 8'hC0) | {4'h0, din[3:0]}) : din;
        push_byte(kind == 2'b00, b,
                  (kind == 2'b01) && (din == 8'h01 || din == 8'h02 || din == 8'h03),
                  tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    // Per-clock comparison with the reference queue.
    always @(negedge clk) begin
        if (rst_n && started) begin
            chk(lcd_rw == 1'b0, 7, "rw not write", lcd_rw, 0);
            if (ready && q_nib.size() != 0)
                chk(1'b0, 10, "ready while nibbles pending", q_nib.size(), 0);
            if (lcd_e && !p_e) begin
                if (q_nib.size() == 0) begin
                    chk(1'b0, 10, "unexpected nibble", lcd_db, 0);
                end else begin
                    bit ers; bit [3:0] en; int eg, et;
                    ers = q_rs.pop_front(); en = q_nib.pop_front();
                    eg = q_gap.pop_front(); et = q_tag.pop_front();
                    chk(lcd_rs == ers, et, "rs", lcd_rs, ers);
                    chk(lcd_db == en, et, "nibble", lcd_db, en);
                    chk(cyc - last_fall >= eg, et, "gap cycles", cyc - last_fall, eg);
                    chk(lcd_db == p_db && lcd_rs == p_rs, 6, "setup", lcd_db, p_db);
                end
            end
            if (lcd_e) begin
                hi++;
                if (!lcd_drive) chk(1'b0, 9, "drive low under strobe", 0, 1);
                if (p_e && (lcd_db != p_db || lcd_rs != p_rs))
                    chk(1'b0, 6, "data moved while strobe high", lcd_db, p_db);
            end
            if (!lcd_e && p_e) begin
                chk(hi >= C, 6, "strobe width", hi, C);
                last_fall = cyc;
                hi = 0;
            end
            if (ready && !p_ready) begin
                chk(q_nib.size() == 0, 10, "ready before queue drained", q_nib.size(), 0);
                chk(cyc - last_fall >= post_need * C, 5, "settle before ready",
                    cyc - last_fall, post_need * C);
                chk(!lcd_drive, 9, "drive still high at ready", lcd_drive, 0);
            end
        end
        p_e = lcd_e; p_rs = lcd_rs; p_db = lcd_db; p_ready = ready;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!ready, 1, "ready in reset", ready, 0);
        chk(!lcd_e, 1, "e in reset", lcd_e, 0);
        chk(!lcd_drive, 1, "drive in reset", lcd_drive, 0);
        chk(!lcd_rw, 1, "rw in reset", lcd_rw, 0);
        // R2 wake-up nibbles; R3 configuration bytes
        push(0, 4'h3, 15000, 2);
        push(0, 4'h3, 4100, 2);
        push(0, 4'h3, 100, 2);
        push(0, 4'h2, 40, 2);
        post_need = 40;
        push_byte(0, 8'h28, 0, 3);
        push_byte(0, 8'h06, 0, 3);
        push_byte(0, 8'h0C, 0, 3);
        push_byte(0, 8'h01, 1, 3);
        rst_n = 1'b1;
        last_fall = cyc;
        started = 1;
        repeat (100) @(negedge clk);
        chk(!ready && !lcd_drive, 1, "ready during start-up", ready, 0);
        while (!ready) @(negedge clk);
        chk(ready && q_nib.size() == 0, 3, "start-up complete", q_nib.size(), 0);

        send(2'b00, 8'h41, 7);   // R7 data write
        // R10: request while busy must be dropped
        chk(!ready, 10, "ready after accept", ready, 0);
        req = 1'b1; cmd_kind = 2'b00; cmd_byte = 8'hAA;
        repeat (3) @(negedge clk);
        req = 1'b0;
        send(2'b01, 8'h0C, 7);   // R7 instruction write
        send(2'b10, 8'h13, 8);   // R8 line 1 column 3 -> 0x83
        send(2'b10, 8'h05, 8);   // R8 line 2 column 5 -> 0xC5
        send(2'b10, 8'hEF, 8);   // R8 upper bits ignored -> 0xCF
        send(2'b11, 8'h1A, 8);   // R8 kind bit 0 ignored -> 0x8A
        send(2'b01, 8'h01, 5);   // R5 clear
        send(2'b00, 8'h7E, 4);   // R4 after long settle
        send(2'b01, 8'h02, 5);   // R5 home
        send(2'b00, 8'hFF, 4);
        @(negedge clk);
        while (!ready) @(negedge clk);
        repeat (200) @(negedge clk);
        chk(q_nib.size() == 0, 10, "all nibbles sent, none extra", q_nib.size(), 0);
        chk(!lcd_drive && ready, 9, "bus released when idle", lcd_drive, 0);
        summary();
    end

endmodule